// File: doc/BRIEF.md
# Configurable IO Pin Multiplexer

This block connects a fixed row of IO pads to a larger set of peripheral functions. GPIO counts as one of those functions. Each pad owns a small selection register. The value held there picks one function for the pad, and that one value steers three signals together: the function's output data drives the pad output, the function's output-enable drives the pad direction, and the pad's input is delivered back to that same function. Functions that only receive data can tie their output-enable low. Functions that only send data can tie it high.

Software reaches the selection registers through a single-cycle request port. A bit-field of the address selects the pad. Every request is answered one cycle later with read data and an error flag. The error flag marks an index with no pad behind it, and an access to such an index leaves every register unchanged.

Pad p offers FUNCS_PER_PAD functions, numbered by selection value s. Value s maps to peripheral function (p + s) mod NUM_FUNCS. All routing is combinational from the registers and the peripheral or pad signals.

Top module: `pinmux_top`

## Requirements
- R1: After reset every selection register holds zero and resp_valid is low.
- R2: A write request (req_write=1) to a mapped index stores req_wdata[SEL_W-1:0] into that pad's register. One cycle later it answers with resp_err=0 and resp_rdata=0.
- R3: A write to an index at or above NUM_PADS changes no register and answers with resp_err=1 and resp_rdata=0.
- R4: A read (req_write=0) of a mapped index answers one cycle later with that register zero-extended to DATA_W and resp_err=0. The value returned is the one held before the request edge.
- R5: A read of an unmapped index answers with resp_rdata=0 and resp_err=1.
- R6: When pad p has selection s < FUNCS_PER_PAD, pad_out[p] equals func_out[f] and pad_oe[p] equals func_oe[f], where f = (p+s) mod NUM_FUNCS.
- R7: When pad p has selection s >= FUNCS_PER_PAD, pad_out[p] and pad_oe[p] are both 0.
- R8: func_in[f] equals pad_in[p] for the lowest-numbered pad p whose selection maps to f. It reads 0 when no pad maps to f.
- R9: The pad index is req_addr[IDX_HI:IDX_LO] (bits 5:2 by default). All other address bits are ignored.
- R10: resp_valid is high exactly in the cycle after a cycle with req_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address; the index field selects the pad |
| req_wdata | input | DATA_W | Write data; only the low SEL_W bits are kept |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_err | output | 1 | Index mapped to no pad |
| resp_rdata | output | DATA_W | Zero-extended selection value, or zero |
| pad_in | input | NUM_PADS | Data arriving from the pads |
| pad_out | output | NUM_PADS | Data driven toward the pads |
| pad_oe | output | NUM_PADS | Pad output-enable |
| func_out | input | NUM_FUNCS | Output data from each peripheral function |
| func_oe | input | NUM_FUNCS | Output-enable from each peripheral function |
| func_in | output | NUM_FUNCS | Input data delivered to each peripheral function |

## Verification
The assertions assume that req_write, req_addr and req_wdata are known in every cycle where req_valid is high. They also assume that peripheral and pad signals settle before the sampling edge. The stimulus changes all inputs only on the falling clock edge and holds them between requests. Response checks rely on the bench never overlapping a request with the response to its predecessor in a way the one-cycle rule forbids. The stimulus therefore issues each request as a single-cycle strobe followed by one idle cycle.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  // peripheral function reached by pad p with selection value s
  function automatic int route_target(int pad, int sel, int nfuncs);
    return (pad + sel) % nfuncs;
  endfunction
endpackage

// File: rtl/pinmux_regbank.sv
module pinmux_regbank #(
  parameter int NUM_PADS = 4,
  parameter int SEL_W    = 2,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int IDX_LO   = 2,
  parameter int IDX_HI   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       resp_valid,
  output logic                       resp_err,
  output logic [DATA_W-1:0]          resp_rdata,
  output logic [NUM_PADS*SEL_W-1:0]  sel_flat
);
  localparam int IDX_W = IDX_HI - IDX_LO + 1;

  logic [SEL_W-1:0] sel_q [NUM_PADS];
  logic [IDX_W-1:0] idx;
  logic             hit;
  logic [SEL_W-1:0] rd_val;
  logic             unused_bits;

  assign idx         = req_addr[IDX_HI:IDX_LO];
  assign unused_bits = ^{req_addr, req_wdata};

  always_comb begin
    hit    = 1'b0;
    rd_val = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (idx == IDX_W'(p)) begin
        hit    = 1'b1;
        rd_val = sel_q[p];
      end
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PADS; gp++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          sel_q[gp] <= '0;
        else if (req_valid && req_write && idx == IDX_W'(gp))
          sel_q[gp] <= req_wdata[SEL_W-1:0];
      end
      assign sel_flat[gp*SEL_W +: SEL_W] = sel_q[gp];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_err   <= !hit;
        resp_rdata <= (hit && !req_write) ? {{(DATA_W-SEL_W){1'b0}}, rd_val} : '0;
      end
    end
  end
endmodule

// File: rtl/pinmux_route.sv
module pinmux_route #(
  parameter int NUM_PADS      = 4,
  parameter int NUM_FUNCS     = 6,
  parameter int FUNCS_PER_PAD = 3,
  parameter int SEL_W         = 2
) (
  input  logic [NUM_PADS*SEL_W-1:0] sel_flat,
  input  logic [NUM_FUNCS-1:0]      func_out,
  input  logic [NUM_FUNCS-1:0]      func_oe,
  output logic [NUM_PADS-1:0]       pad_out,
  output logic [NUM_PADS-1:0]       pad_oe
);
  import pinmux_pkg::*;

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PADS; gp++) begin : g_pad
      logic [SEL_W-1:0] sel;
      assign sel = sel_flat[gp*SEL_W +: SEL_W];
      always_comb begin
        pad_out[gp] = 1'b0;
        pad_oe[gp]  = 1'b0;
        for (int s = 0; s < FUNCS_PER_PAD; s++) begin
          if (int'(sel) == s) begin
            pad_out[gp] = func_out[route_target(gp, s, NUM_FUNCS)];
            pad_oe[gp]  = func_oe[route_target(gp, s, NUM_FUNCS)];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pinmux_gather.sv
module pinmux_gather #(
  parameter int NUM_PADS      = 4,
  parameter int NUM_FUNCS     = 6,
  parameter int FUNCS_PER_PAD = 3,
  parameter int SEL_W         = 2
) (
  input  logic [NUM_PADS*SEL_W-1:0] sel_flat,
  input  logic [NUM_PADS-1:0]       pad_in,
  output logic [NUM_FUNCS-1:0]      func_in
);
  import pinmux_pkg::*;

  genvar gf;
  generate
    for (gf = 0; gf < NUM_FUNCS; gf++) begin : g_func
      always_comb begin
        func_in[gf] = 1'b0;
        // descending scan so the lowest matching pad is applied last
        for (int p = NUM_PADS - 1; p >= 0; p--) begin
          if (int'(sel_flat[p*SEL_W +: SEL_W]) < FUNCS_PER_PAD &&
              route_target(p, int'(sel_flat[p*SEL_W +: SEL_W]), NUM_FUNCS) == gf)
            func_in[gf] = pad_in[p];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pinmux_top.sv
module pinmux_top #(
  parameter int NUM_PADS      = 4,
  parameter int NUM_FUNCS     = 6,
  parameter int FUNCS_PER_PAD = 3,
  parameter int SEL_W         = 2,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter int IDX_LO        = 2,
  parameter int IDX_HI        = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 resp_valid,
  output logic                 resp_err,
  output logic [DATA_W-1:0]    resp_rdata,
  input  logic [NUM_PADS-1:0]  pad_in,
  output logic [NUM_PADS-1:0]  pad_out,
  output logic [NUM_PADS-1:0]  pad_oe,
  input  logic [NUM_FUNCS-1:0] func_out,
  input  logic [NUM_FUNCS-1:0] func_oe,
  output logic [NUM_FUNCS-1:0] func_in
);
  logic [NUM_PADS*SEL_W-1:0] sel_flat;

  pinmux_regbank #(
    .NUM_PADS(NUM_PADS), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .IDX_LO(IDX_LO), .IDX_HI(IDX_HI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .sel_flat(sel_flat)
  );

  pinmux_route #(
    .NUM_PADS(NUM_PADS), .NUM_FUNCS(NUM_FUNCS),
    .FUNCS_PER_PAD(FUNCS_PER_PAD), .SEL_W(SEL_W)
  ) u_route (
    .sel_flat(sel_flat), .func_out(func_out), .func_oe(func_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  pinmux_gather #(
    .NUM_PADS(NUM_PADS), .NUM_FUNCS(NUM_FUNCS),
    .FUNCS_PER_PAD(FUNCS_PER_PAD), .SEL_W(SEL_W)
  ) u_gather (
    .sel_flat(sel_flat), .pad_in(pad_in), .func_in(func_in)
  );
endmodule

// File: rtl/pinmux_checker.sv
module pinmux_checker #(
  parameter int NUM_PADS      = 4,
  parameter int NUM_FUNCS     = 6,
  parameter int FUNCS_PER_PAD = 3,
  parameter int SEL_W         = 2,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter int IDX_LO        = 2,
  parameter int IDX_HI        = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [ADDR_W-1:0]         req_addr,
  input logic                      resp_valid,
  input logic                      resp_err,
  input logic [DATA_W-1:0]         resp_rdata,
  input logic [NUM_PADS*SEL_W-1:0] sel_flat,
  input logic [NUM_FUNCS-1:0]      func_out,
  input logic [NUM_FUNCS-1:0]      func_oe,
  input logic [NUM_PADS-1:0]       pad_out,
  input logic [NUM_PADS-1:0]       pad_oe
);
  logic mapped;
  assign mapped = int'(req_addr[IDX_HI:IDX_LO]) < NUM_PADS;

  assert_resp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  assert_resp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  assert_unmapped_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mapped) |=> resp_err);
  assert_mapped_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mapped) |=> !resp_err);
  assert_err_data_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err) |-> resp_rdata == '0);
  assert_write_data_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> resp_rdata == '0);
  assert_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mapped) |=> $stable(sel_flat));

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PADS; gp++) begin : g_chk
      logic [SEL_W-1:0] s;
      assign s = sel_flat[gp*SEL_W +: SEL_W];
      assert_off_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(s) >= FUNCS_PER_PAD) |-> (!pad_out[gp] && !pad_oe[gp]));
      assert_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(s) < FUNCS_PER_PAD) |->
          (pad_out[gp] == func_out[(gp + int'(s)) % NUM_FUNCS] &&
           pad_oe[gp]  == func_oe[(gp + int'(s)) % NUM_FUNCS]));
    end
  endgenerate
endmodule

bind pinmux_top pinmux_checker #(
  .NUM_PADS(NUM_PADS), .NUM_FUNCS(NUM_FUNCS), .FUNCS_PER_PAD(FUNCS_PER_PAD),
  .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .IDX_LO(IDX_LO), .IDX_HI(IDX_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .resp_valid(resp_valid), .resp_err(resp_err),
  .resp_rdata(resp_rdata), .sel_flat(sel_flat), .func_out(func_out),
  .func_oe(func_oe), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/test_pinmux_top.sv
`timescale 1ns/1ps
module test_pinmux_top;
  localparam int NP = 4, NF = 6, FPP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic [3:0]  pad_in = '0;
  logic [3:0]  pad_out, pad_oe;
  logic [5:0]  func_out = '0, func_oe = '0;
  logic [5:0]  func_in;

  int checks = 0, fails = 0;
  int msel [NP];
  bit done = 0;

  always #2 clk = ~clk;

  pinmux_top i_pinmux_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_err(resp_err), .resp_rdata(resp_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .func_out(func_out),
    .func_oe(func_oe), .func_in(func_in)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-cycle request, sampled at the negedge after the capturing edge
  task automatic access(bit wr, int idx, logic [31:0] data, logic [1:0] junk_lo, logic [1:0] junk_hi);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_addr = {junk_hi, 4'(idx), junk_lo}; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_sel(int p, int s);
    access(1, p, {30'h2aaaaaaa, 2'(s)}, 2'b01, 2'b10);
    check("R2 write err", {31'b0, resp_err}, 0);
    check("R2 write data", resp_rdata, 0);
    check("R10 resp_valid", {31'b0, resp_valid}, 1);
    msel[p] = s;
  endtask

  task automatic check_pads(string tag);
    for (int p = 0; p < NP; p++) begin
      logic eo, ee;
      if (msel[p] < FPP) begin
        eo = func_out[(p + msel[p]) % NF];
        ee = func_oe[(p + msel[p]) % NF];
      end else begin
        eo = 1'b0; ee = 1'b0;
      end
      check(tag, {31'b0, pad_out[p]}, {31'b0, eo});
      check(tag, {31'b0, pad_oe[p]}, {31'b0, ee});
    end
  endtask

  task automatic check_inputs();
    for (int v = 0; v < 16; v++) begin
      logic [5:0] exp;
      pad_in = 4'(v);
      #1;
      exp = '0;
      for (int f = 0; f < NF; f++)
        for (int p = NP - 1; p >= 0; p--)
          if (msel[p] < FPP && (p + msel[p]) % NF == f) exp[f] = pad_in[p];
      check("R8 func_in", {26'b0, func_in}, {26'b0, exp});
    end
  endtask

  initial begin
    for (int p = 0; p < NP; p++) msel[p] = 0;
    #9;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 resp_valid", {31'b0, resp_valid}, 0);
    for (int p = 0; p < NP; p++) begin
      access(0, p, 0, 2'b00, 2'b00);
      check("R1 reset value", resp_rdata, 0);
    end
    @(negedge clk);
    check("R10 idle", {31'b0, resp_valid}, 0);

    // R6 R7: every pad, every selection value, several data patterns
    for (int p = 0; p < NP; p++) begin
      for (int s = 0; s < 4; s++) begin
        set_sel(p, s);
        for (int k = 0; k < 4; k++) begin
          case (k)
            0: func_out = 6'b101010;
            1: func_out = 6'b010101;
            2: func_out = 6'b111000;
            default: func_out = 6'b000111;
          endcase
          func_oe = ~func_out ^ 6'(k);
          #1;
          check_pads(s < FPP ? "R6 route" : "R7 off pad");
        end
      end
    end

    // R8: priority and default-zero under several configurations
    set_sel(0, 1); set_sel(1, 0); set_sel(2, 0); set_sel(3, 3);
    check_inputs();
    set_sel(0, 2); set_sel(1, 1); set_sel(2, 3); set_sel(3, 2);
    check_inputs();
    set_sel(0, 0); set_sel(1, 2); set_sel(2, 1); set_sel(3, 0);
    check_inputs();

    // R3: unmapped writes change nothing
    for (int i = NP; i < 16; i++) begin
      access(1, i, 32'hffff_ffff, 2'b11, 2'b11);
      check("R3 unmapped write err", {31'b0, resp_err}, 1);
      check("R3 unmapped write data", resp_rdata, 0);
    end

    // R4 R5 R9: read every index with stray address bits set
    for (int i = 0; i < 16; i++) begin
      access(0, i, 32'h0, 2'b11, 2'b01);
      if (i < NP) begin
        check("R4 read data", resp_rdata, 32'(msel[i]));
        check("R4 read err", {31'b0, resp_err}, 0);
      end else begin
        check("R5 unmapped read data", resp_rdata, 0);
        check("R5 unmapped read err", {31'b0, resp_err}, 1);
      end
    end
    check_pads("R9 pads after sweep");

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule